// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Tracker

This block holds the single atomic reservation that a core's data side keeps between a load-reserve and the store-conditional that follows it. A load-reserve records the cache line it touched and raises a valid flag. From then on the block watches a snoop port for writes by another on-chip master. A write that lands anywhere in the reserved line drops the reservation.

For every accepted access the block decides whether an external bus transfer is needed, and which attributes that transfer carries. A miss to a cacheable, unlocked region is treated as private to this core, so it travels without the reservation attribute. A miss to a cache-inhibited region, or one made while the cache is locked, travels as a single-beat transfer that carries the reservation. A store-conditional always goes out as a write-through write, whatever the region's own write policy.

The block then judges the store-conditional. If the reservation is gone, it cancels the bus write and reports failure on the next cycle. If the reservation is intact, it waits for the bus acknowledge, reports success and requests a cache line update only when the store hit. The reservation is consumed in either case.

Top module: `lrsc_reserve_unit`

## Requirements
- R1: After a synchronous reset, `resv_valid`, `bus_req` and `resp_done` are 0 and `req_ready` is 1.
- R2: An accepted load-reserve (`req_sc`=0) sets `resv_valid` in the cycle after acceptance and records the line `req_addr[ADDR_W-1:log2(LINE_BYTES)]`. A load-reserve accepted in the same cycle as a snoop takes priority over that snoop.
- R3: A load-reserve that misses (`cache_hit`=0) in a cacheable (`attr_cacheable`=1), unlocked region raises `bus_req` in the cycle after acceptance with `bus_we`=0, `bus_resv`=0, `bus_single`=0 and `bus_addr`=`req_addr`.
- R4: A load-reserve that misses in a cache-inhibited region, or while `attr_locked`=1, raises `bus_req` with `bus_we`=0, `bus_resv`=1 and `bus_single`=1.
- R5: An access that needs no bus transfer, such as a load-reserve hit, pulses `resp_done` for one cycle in the cycle after acceptance, with `resp_pass`=0 and `bus_req` held at 0.
- R6: A snoop with `snp_valid`=1 and `snp_write`=1 whose line equals the reserved line, at any byte offset, clears `resv_valid` at that clock edge. A snoop read, or a snoop write to another line, leaves the reservation in place.
- R7: A store-conditional with an intact reservation raises `bus_req` with `bus_we`=1, `bus_wt`=1 and `bus_single`=1, whatever `attr_wr_thru` says. It sets `bus_resv`=1 only on a miss to an inhibited or locked region.
- R8: A request is complete in the cycle after `bus_ack` is sampled high: `bus_req` falls and `resp_done` pulses. For a store-conditional, `resp_pass`=1 and `line_upd`=1 only if the store hit.
- R9: A store-conditional with no reservation, or with a reservation on a different line, makes no bus request. It pulses `resp_done` with `resp_pass`=0 and `line_upd`=0 in the cycle after acceptance.
- R10: An accepted store-conditional clears `resv_valid`, whether it passes or fails.
- R11: A store-conditional accepted in the same cycle as a matching snoop write fails.
- R12: While a bus transfer is outstanding, `req_ready` is 0 and requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core access request |
| req_sc | input | 1 | 1 = store-conditional, 0 = load-reserve |
| req_addr | input | ADDR_W | Byte address of the access |
| attr_cacheable | input | 1 | Region is cacheable |
| attr_wr_thru | input | 1 | Region is write-through |
| attr_locked | input | 1 | Cache is locked |
| cache_hit | input | 1 | Access hit in the data cache |
| req_ready | output | 1 | Block can accept a request |
| snp_valid | input | 1 | Snooped access by another master |
| snp_write | input | 1 | Snooped access is a write |
| snp_addr | input | ADDR_W | Snooped byte address |
| bus_ack | input | 1 | External transfer completed |
| bus_req | output | 1 | External transfer request |
| bus_we | output | 1 | Transfer is a write |
| bus_resv | output | 1 | Transfer carries the reservation attribute |
| bus_single | output | 1 | Single-beat transfer |
| bus_wt | output | 1 | Write-through handling |
| bus_addr | output | ADDR_W | Transfer address |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_pass | output | 1 | Store-conditional success flag |
| line_upd | output | 1 | Update the cache line |
| resv_valid | output | 1 | A reservation is held |

## Verification
The bench builds the block with a 16-bit address and 16-byte lines. Snoops at offsets inside the reserved line and just outside it are therefore easy to write by hand. Reservations on neighbouring lines then differ in a single line-number bit, so a compare that drops or shifts a bit shows up as a wrong pass or fail.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUS  = 1'b1
  } ctrl_state_t;

  typedef struct packed {
    logic need_bus;
    logic carry_resv;
    logic single_beat;
    logic force_wt;
  } bus_attr_t;

endpackage

// File: rtl/lrsc_bus_attr.sv
module lrsc_bus_attr
  import lrsc_pkg::*;
(
  input  logic      is_sc,
  input  logic      cacheable,
  input  logic      wr_thru,
  input  logic      locked,
  input  logic      hit,
  output bus_attr_t attr
);
  logic private_region;

  always_comb begin
    private_region   = cacheable & ~locked;
    attr.need_bus    = is_sc | ~hit;
    attr.carry_resv  = ~hit & ~private_region;
    attr.single_beat = is_sc | ~private_region;
    attr.force_wt    = is_sc | wr_thru;
  end
endmodule

// File: rtl/lrsc_resv_track.sv
module lrsc_resv_track #(
  parameter int LINE_W = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [LINE_W-1:0] set_line,
  input  logic              consume_en,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [LINE_W-1:0] snp_line,
  input  logic [LINE_W-1:0] query_line,
  output logic              vld,
  output logic [LINE_W-1:0] line_q,
  output logic              intact
);
  logic snp_kill;

  always_comb begin
    snp_kill = vld & snp_valid & snp_write & (snp_line == line_q);
    intact   = vld & (query_line == line_q) & ~snp_kill;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= 1'b0;
      line_q <= '0;
    end else if (set_en) begin
      vld    <= 1'b1;
      line_q <= set_line;
    end else if (consume_en || snp_kill) begin
      vld <= 1'b0;
    end
  end
endmodule

// File: rtl/lrsc_ctrl.sv
module lrsc_ctrl
  import lrsc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_fire,
  input  logic              req_sc,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              hit,
  input  bus_attr_t         attr,
  input  logic              sc_ok,
  input  logic              bus_ack,
  output logic              ready,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_resv,
  output logic              bus_single,
  output logic              bus_wt,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              resp_done,
  output logic              resp_pass,
  output logic              line_upd
);
  ctrl_state_t state;
  logic        sc_q;
  logic        hit_q;

  assign ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sc_q       <= 1'b0;
      hit_q      <= 1'b0;
      bus_req    <= 1'b0;
      bus_we     <= 1'b0;
      bus_resv   <= 1'b0;
      bus_single <= 1'b0;
      bus_wt     <= 1'b0;
      bus_addr   <= '0;
      resp_done  <= 1'b0;
      resp_pass  <= 1'b0;
      line_upd   <= 1'b0;
    end else begin
      resp_done <= 1'b0;
      resp_pass <= 1'b0;
      line_upd  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_fire) begin
            sc_q  <= req_sc;
            hit_q <= hit;
            if (req_sc && !sc_ok) begin
              resp_done <= 1'b1;
            end else if (attr.need_bus) begin
              state      <= ST_BUS;
              bus_req    <= 1'b1;
              bus_we     <= req_sc;
              bus_resv   <= attr.carry_resv;
              bus_single <= attr.single_beat;
              bus_wt     <= attr.force_wt;
              bus_addr   <= req_addr;
            end else begin
              resp_done <= 1'b1;
            end
          end
        end
        ST_BUS: begin
          if (bus_ack) begin
            state      <= ST_IDLE;
            bus_req    <= 1'b0;
            bus_we     <= 1'b0;
            bus_resv   <= 1'b0;
            bus_single <= 1'b0;
            bus_wt     <= 1'b0;
            resp_done  <= 1'b1;
            resp_pass  <= sc_q;
            line_upd   <= sc_q & hit_q;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lrsc_reserve_unit.sv
module lrsc_reserve_unit
  import lrsc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_sc,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              attr_cacheable,
  input  logic              attr_wr_thru,
  input  logic              attr_locked,
  input  logic              cache_hit,
  output logic              req_ready,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              bus_ack,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_resv,
  output logic              bus_single,
  output logic              bus_wt,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              resp_done,
  output logic              resp_pass,
  output logic              line_upd,
  output logic              resv_valid
);
  localparam int OFF_W  = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 1;
  localparam int LINE_W = ADDR_W - OFF_W;

  logic              req_fire;
  logic              sc_ok;
  logic [LINE_W-1:0] resv_line_q;
  bus_attr_t         attr;

  assign req_fire = req_valid & req_ready;

  lrsc_bus_attr u_attr (
    .is_sc     (req_sc),
    .cacheable (attr_cacheable),
    .wr_thru   (attr_wr_thru),
    .locked    (attr_locked),
    .hit       (cache_hit),
    .attr      (attr)
  );

  lrsc_resv_track #(.LINE_W(LINE_W)) u_track (
    .clk        (clk),
    .rst        (rst),
    .set_en     (req_fire & ~req_sc),
    .set_line   (req_addr[ADDR_W-1:OFF_W]),
    .consume_en (req_fire & req_sc),
    .snp_valid  (snp_valid),
    .snp_write  (snp_write),
    .snp_line   (snp_addr[ADDR_W-1:OFF_W]),
    .query_line (req_addr[ADDR_W-1:OFF_W]),
    .vld        (resv_valid),
    .line_q     (resv_line_q),
    .intact     (sc_ok)
  );

  lrsc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_fire   (req_fire),
    .req_sc     (req_sc),
    .req_addr   (req_addr),
    .hit        (cache_hit),
    .attr       (attr),
    .sc_ok      (sc_ok),
    .bus_ack    (bus_ack),
    .ready      (req_ready),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_resv   (bus_resv),
    .bus_single (bus_single),
    .bus_wt     (bus_wt),
    .bus_addr   (bus_addr),
    .resp_done  (resp_done),
    .resp_pass  (resp_pass),
    .line_upd   (line_upd)
  );
endmodule

// File: rtl/lrsc_reserve_chk.sv
module lrsc_reserve_chk #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 28
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_sc,
  input logic              req_ready,
  input logic              snp_valid,
  input logic              snp_write,
  input logic [LINE_W-1:0] snp_line,
  input logic [LINE_W-1:0] resv_line_q,
  input logic              bus_req,
  input logic              bus_we,
  input logic              bus_resv,
  input logic              bus_single,
  input logic              bus_wt,
  input logic              resp_done,
  input logic              resp_pass,
  input logic              line_upd,
  input logic              resv_valid
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!resv_valid && !bus_req && !resp_done && req_ready));

  // R4
  resv_single_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && bus_resv) |-> bus_single);

  // R7
  sc_write_thru_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we) |-> (bus_wt && bus_single));

  // R8
  upd_needs_pass_chk: assert property (@(posedge clk) disable iff (rst)
    line_upd |-> (resp_done && resp_pass));

  // R8
  ack_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_req) |-> resp_done);

  // R12
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> !req_ready);

  // R6
  snoop_kill_chk: assert property (@(posedge clk) disable iff (rst)
    (resv_valid && snp_valid && snp_write && (snp_line == resv_line_q)
     && !(req_valid && req_ready && !req_sc)) |=> !resv_valid);

  // R10
  sc_consume_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_sc) |=> !resv_valid);
endmodule

bind lrsc_reserve_unit lrsc_reserve_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_sc      (req_sc),
  .req_ready   (req_ready),
  .snp_valid   (snp_valid),
  .snp_write   (snp_write),
  .snp_line    (snp_addr[ADDR_W-1:OFF_W]),
  .resv_line_q (resv_line_q),
  .bus_req     (bus_req),
  .bus_we      (bus_we),
  .bus_resv    (bus_resv),
  .bus_single  (bus_single),
  .bus_wt      (bus_wt),
  .resp_done   (resp_done),
  .resp_pass   (resp_pass),
  .line_upd    (line_upd),
  .resv_valid  (resv_valid)
);

// File: tb/lrsc_reserve_unit_tb.sv
module lrsc_reserve_unit_tb;
  localparam int AW = 16;
  localparam int LB = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_sc = 0;
  logic [AW-1:0] req_addr = '0;
  logic attr_cacheable = 0, attr_wr_thru = 0, attr_locked = 0, cache_hit = 0;
  logic req_ready;
  logic snp_valid = 0, snp_write = 0;
  logic [AW-1:0] snp_addr = '0;
  logic bus_ack = 0;
  logic bus_req, bus_we, bus_resv, bus_single, bus_wt;
  logic [AW-1:0] bus_addr;
  logic resp_done, resp_pass, line_upd, resv_valid;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  lrsc_reserve_unit #(.ADDR_W(AW), .LINE_BYTES(LB)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_sc(req_sc), .req_addr(req_addr),
    .attr_cacheable(attr_cacheable), .attr_wr_thru(attr_wr_thru), .attr_locked(attr_locked),
    .cache_hit(cache_hit), .req_ready(req_ready), .snp_valid(snp_valid), .snp_write(snp_write),
    .snp_addr(snp_addr), .bus_ack(bus_ack), .bus_req(bus_req), .bus_we(bus_we),
    .bus_resv(bus_resv), .bus_single(bus_single), .bus_wt(bus_wt), .bus_addr(bus_addr),
    .resp_done(resp_done), .resp_pass(resp_pass), .line_upd(line_upd), .resv_valid(resv_valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one request for one cycle; returns just after the accepting edge
  task automatic issue(input logic sc, input logic [AW-1:0] a, input logic cach,
                       input logic wt, input logic lock, input logic hit,
                       input logic snp_w = 0, input logic [AW-1:0] sa = '0);
    @(negedge clk);
    req_valid = 1; req_sc = sc; req_addr = a;
    attr_cacheable = cach; attr_wr_thru = wt; attr_locked = lock; cache_hit = hit;
    snp_valid = snp_w; snp_write = snp_w; snp_addr = sa;
    @(posedge clk); #1;
    req_valid = 0; snp_valid = 0; snp_write = 0;
  endtask

  task automatic ack();
    @(negedge clk); bus_ack = 1;
    @(posedge clk); #1; bus_ack = 0;
  endtask

  task automatic snoop(input logic wr, input logic [AW-1:0] a);
    @(negedge clk); snp_valid = 1; snp_write = wr; snp_addr = a;
    @(posedge clk); #1; snp_valid = 0; snp_write = 0;
  endtask

  task automatic t_reset();
    chk("R1 resv_valid", resv_valid, 0);
    chk("R1 bus_req", bus_req, 0);
    chk("R1 resp_done", resp_done, 0);
    chk("R1 req_ready", req_ready, 1);
  endtask

  task automatic t_lr_cacheable_miss();
    issue(0, 16'h1234, 1, 0, 0, 0);
    chk("R2 resv_valid", resv_valid, 1);
    chk("R3 bus_req", bus_req, 1);
    chk("R3 bus_we", bus_we, 0);
    chk("R3 bus_resv", bus_resv, 0);
    chk("R3 bus_single", bus_single, 0);
    chk("R3 bus_addr", bus_addr, 16'h1234);
    chk("R12 not ready", req_ready, 0);
    ack();
    chk("R8 done", resp_done, 1);
    chk("R8 lr pass", resp_pass, 0);
    chk("R8 bus_req fell", bus_req, 0);
  endtask

  task automatic t_lr_inhibited_locked();
    issue(0, 16'h2000, 0, 0, 0, 0);
    chk("R4 inh resv", bus_resv, 1);
    chk("R4 inh single", bus_single, 1);
    ack();
    issue(0, 16'h2010, 1, 0, 1, 0);
    chk("R4 lock resv", bus_resv, 1);
    chk("R4 lock single", bus_single, 1);
    ack();
  endtask

  task automatic t_lr_hit();
    issue(0, 16'h3000, 1, 0, 0, 1);
    chk("R5 no bus", bus_req, 0);
    chk("R5 done", resp_done, 1);
    chk("R5 pass", resp_pass, 0);
    @(posedge clk); #1;
    chk("R5 done one cycle", resp_done, 0);
  endtask

  task automatic t_busy_ignored();
    issue(0, 16'h4000, 0, 0, 0, 0);
    issue(0, 16'h5000, 0, 0, 0, 0);
    chk("R12 addr held", bus_addr, 16'h4000);
    ack();
    issue(1, 16'h4004, 1, 0, 0, 1);
    chk("R12 resv still old line", bus_req, 1);
    ack();
    chk("R12 sc pass", resp_pass, 1);
  endtask

  task automatic t_sc_pass_hit();
    issue(0, 16'h6000, 1, 0, 0, 1);
    issue(1, 16'h6004, 1, 0, 0, 1);
    chk("R7 bus_we", bus_we, 1);
    chk("R7 bus_wt", bus_wt, 1);
    chk("R7 bus_single", bus_single, 1);
    chk("R7 bus_resv", bus_resv, 0);
    chk("R10 consumed", resv_valid, 0);
    chk("R8 no early done", resp_done, 0);
    ack();
    chk("R8 done", resp_done, 1);
    chk("R8 pass", resp_pass, 1);
    chk("R8 line_upd", line_upd, 1);
  endtask

  task automatic t_sc_pass_miss_inhibited();
    issue(0, 16'h7000, 0, 0, 0, 0);
    ack();
    issue(1, 16'h700C, 0, 0, 0, 0);
    chk("R7 inh resv", bus_resv, 1);
    chk("R7 inh wt", bus_wt, 1);
    ack();
    chk("R8 pass miss", resp_pass, 1);
    chk("R8 no upd on miss", line_upd, 0);
  endtask

  task automatic t_sc_fail();
    issue(1, 16'h8000, 1, 1, 0, 1);
    chk("R9 no bus", bus_req, 0);
    chk("R9 done", resp_done, 1);
    chk("R9 pass", resp_pass, 0);
    chk("R9 upd", line_upd, 0);
    issue(0, 16'h9000, 1, 0, 0, 1);
    issue(1, 16'h9010, 1, 0, 0, 1);
    chk("R9 other line fail", resp_pass, 0);
    chk("R9 other line no bus", bus_req, 0);
    chk("R10 consumed on fail", resv_valid, 0);
  endtask

  task automatic t_snoop();
    issue(0, 16'hA000, 1, 0, 0, 1);
    snoop(0, 16'hA000);
    chk("R6 read keeps", resv_valid, 1);
    snoop(1, 16'hA010);
    chk("R6 other line keeps", resv_valid, 1);
    snoop(1, 16'hA00F);
    chk("R6 write clears", resv_valid, 0);
    issue(1, 16'hA000, 1, 0, 0, 1);
    chk("R6 sc after snoop fails", resp_done & ~resp_pass, 1);
    issue(0, 16'hB000, 1, 0, 0, 1, 1, 16'hB000);
    chk("R2 lr beats snoop", resv_valid, 1);
  endtask

  task automatic t_snoop_same_cycle();
    issue(0, 16'hC000, 1, 0, 0, 1);
    issue(1, 16'hC000, 1, 0, 0, 1, 1, 16'hC008);
    chk("R11 fail", resp_pass, 0);
    chk("R11 done", resp_done, 1);
    chk("R11 no bus", bus_req, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst = 0;
    t_reset();
    t_lr_cacheable_miss();
    t_lr_inhibited_locked();
    t_lr_hit();
    t_busy_ignored();
    t_sc_pass_hit();
    t_sc_pass_miss_inhibited();
    t_sc_fail();
    t_snoop();
    t_snoop_same_cycle();
    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule